// File: doc/BRIEF.md
# Toggle-Mode Timer Output Stage

This block turns one shared up-counter into a set of square-wave output pins. The counter starts at zero, counts up to a programmable period value and wraps to zero, so one full period lasts period+1 clock cycles. Each output channel has its own compare value. In the cycle where the counter equals that value, the channel's internal toggle state flips. The pin therefore shows a square wave with half-periods of period+1 cycles, phase-shifted by the compare value.

Each channel also has a polarity bit, a 2-bit output-mode field and a software hold bit. While the hold bit is set, or the mode field holds anything other than the toggle mode, the pin sits at its inactive level. Releasing the hold drives the pin active straight away, without waiting for a compare match. The toggle state is left inactive at release, so the first match flips it to active and the pin stays high through it. The first active pulse after a release is therefore longer than the steady ones by the wait from release to that first match. This stretch is intended behaviour. Software programs the stage through a single-cycle synchronous write port.

Top module: `toggle_out_stage`

## Requirements
- R1: A synchronous reset clears the counter, the period register and every compare register. It sets every channel's hold bit and clears its polarity and mode fields, so every pin reads 0 in the first sample after reset.
- R2: The counter runs 0, 1, … up to the period register value, then returns to 0. One full cycle takes period+1 clocks.
- R3: On a write, address 0 loads the period, address 1+k loads the compare value of channel k, and address 1+NUM_CH+k loads the control word of channel k. In the control word, bit 0 is the hold bit, bit 1 is polarity and bits 3:2 are the mode. A write takes effect at the clock edge where it is sampled.
- R4: While a channel is running and is neither forced nor being released, each cycle where counter equals compare flips its pin at the next edge. In steady state the pin is active for period+1 cycles and inactive for period+1 cycles.
- R5: Once a channel's hold bit is 1, its pin is inactive from the second edge after the write and stays inactive whatever compare matches occur.
- R6: When a channel leaves the held condition, its pin becomes active at the second edge after the write, before any compare match.
- R7: After a release in a cycle where the counter is c and c differs from the compare value m, the first active pulse lasts ((m−c) mod (period+1)) + (period+1) cycles.
- R8: If the first cycle after release is also a compare-match cycle, the release wins for that cycle. The pin goes active, and the next match makes it inactive, giving a first active pulse of exactly period+1 cycles.
- R9: The inactive level of a pin equals its polarity bit, and the active level is the inverse.
- R10: A mode field other than 01 holds the channel inactive just as the hold bit does. Clearing the hold bit then causes no activation.
- R11: Writing one channel's compare or control value does not change any other channel's pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register address of the write |
| wr_data | input | CNT_W | Write data |
| pin_o | output | NUM_CH | Registered output pin of each channel |

## Verification
A bad counter or wrap shows at the pins within one period, because the inactive and active intervals depart from period+1 cycles. A wrong forced-activation flag or toggle reload is visible in the length of the first pulse after release. That length is predicted exactly from the counter phase at release, including the case where release coincides with a match. A broken hold path or mode gate shows as an active sample within two edges of the write. The sample is taken on a channel whose compare matches repeatedly during the observation window.

// File: rtl/toc_pkg.sv
package toc_pkg;

  // Per-channel control word, packed MSB first: mode[3:2], pol[1], hold_req[0]
  typedef struct packed {
    logic [1:0] mode;
    logic       pol;
    logic       hold_req;
  } chan_ctrl_t;

  localparam int         CTRL_W       = $bits(chan_ctrl_t);
  localparam logic [1:0] MODE_TOGGLE1 = 2'b01;

  localparam chan_ctrl_t CTRL_RST = '{mode: 2'b00, pol: 1'b0, hold_req: 1'b1};

endpackage

// File: rtl/toc_regs.sv
module toc_regs
  import toc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [CNT_W-1:0]                   wr_data,
  output logic [CNT_W-1:0]                   period_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]       cmp_o,
  output chan_ctrl_t [NUM_CH-1:0]            ctrl_o
);

  localparam logic [ADDR_W-1:0] PER_ADDR = '0;

  always_ff @(posedge clk) begin
    if (rst)
      period_o <= '0;
    else if (wr_en && wr_addr == PER_ADDR)
      period_o <= wr_data;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(1 + k);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(1 + NUM_CH + k);

    always_ff @(posedge clk) begin
      if (rst)
        cmp_o[k] <= '0;
      else if (wr_en && wr_addr == CMP_ADDR)
        cmp_o[k] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst)
        ctrl_o[k] <= CTRL_RST;
      else if (wr_en && wr_addr == CTL_ADDR)
        ctrl_o[k] <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    // R3: control write lands at the sampling edge
    a_r3_ctrl_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == CTL_ADDR) |=> ctrl_o[k] == chan_ctrl_t'($past(wr_data[CTRL_W-1:0])));
  end

  // R3: period write lands at the sampling edge
  a_r3_period_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == PER_ADDR) |=> period_o == $past(wr_data));

endmodule

// File: rtl/toc_counter.sv
module toc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic at_top;
  assign at_top = (cnt_o == period_i);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_o <= '0;
    else if (at_top)
      cnt_o <= '0;
    else
      cnt_o <= cnt_o + CNT_W'(1);
  end

  // R2: wrap to zero after reaching the period value
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == period_i) |=> cnt_o == '0);

  // R2: otherwise step by one
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_o != period_i) |=> cnt_o == $past(cnt_o) + CNT_W'(1));

endmodule

// File: rtl/toc_channel.sv
module toc_channel
  import toc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  chan_ctrl_t       ctrl_i,
  output logic             pin_o
);

  logic hold, hold_q, rel, match;
  logic tgl_q, frc_q, tgl_d, frc_d, act_d;

  // Held when software requests it or the mode is not the toggle mode (R10)
  assign hold  = ctrl_i.hold_req | (ctrl_i.mode != MODE_TOGGLE1);
  assign rel   = hold_q & ~hold;
  assign match = (cnt_i == cmp_i);

  always_comb begin
    tgl_d = tgl_q;
    frc_d = frc_q;
    if (hold) begin
      tgl_d = 1'b0;
      frc_d = 1'b0;
    end else if (rel) begin
      if (match) begin
        // R8: release wins, next match drives inactive
        tgl_d = 1'b1;
        frc_d = 1'b0;
      end else begin
        // R6/R7: forced active, toggle left inactive so first match stretches
        tgl_d = 1'b0;
        frc_d = 1'b1;
      end
    end else if (match) begin
      tgl_d = ~tgl_q;
      frc_d = 1'b0;
    end
    act_d = ~hold & (tgl_d | frc_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b1;
      tgl_q  <= 1'b0;
      frc_q  <= 1'b0;
      pin_o  <= 1'b0;
    end else begin
      hold_q <= hold;
      tgl_q  <= tgl_d;
      frc_q  <= frc_d;
      pin_o  <= act_d ^ ctrl_i.pol;
    end
  end

  // R5: held channel drives the inactive level
  a_r5_held_inactive: assert property (@(posedge clk) disable iff (rst)
    hold |=> pin_o == $past(ctrl_i.pol));

  // R6: release activates at once
  a_r6_release_active: assert property (@(posedge clk) disable iff (rst)
    rel |=> pin_o != $past(ctrl_i.pol));

  // R7: forced activation persists until match hands over
  a_r7_forced_stays: assert property (@(posedge clk) disable iff (rst)
    (frc_q && !hold) |=> pin_o != $past(ctrl_i.pol));

  // R4: a match in running state flips the pin
  a_r4_toggle: assert property (@(posedge clk) disable iff (rst)
    (!hold && !rel && !frc_q && match && $stable(ctrl_i.pol)) |=> pin_o != $past(pin_o));

endmodule

// File: rtl/toggle_out_stage.sv
module toggle_out_stage
  import toc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = $clog2(2 * NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pin_o
);

  logic [CNT_W-1:0]             period;
  logic [CNT_W-1:0]             cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  chan_ctrl_t [NUM_CH-1:0]      ctrl;

  toc_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .period_o (period),
    .cmp_o    (cmp),
    .ctrl_o   (ctrl)
  );

  toc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .period_i (period),
    .cnt_o    (cnt)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_out
    toc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .cnt_i  (cnt),
      .cmp_i  (cmp[k]),
      .ctrl_i (ctrl[k]),
      .pin_o  (pin_o[k])
    );
  end

  // R1: pins low in the cycle after reset
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> pin_o == '0);

endmodule

// File: tb/test_toggle_out_stage.sv
module test_toggle_out_stage;

  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 4;
  localparam int PER    = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [NUM_CH-1:0] pin_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Reference counter derived from R2/R3
  int cnt_m = 0;
  int per_m = 0;

  always #10 clk = ~clk;

  toggle_out_stage #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_toggle_out_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_o(pin_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      cnt_m = 0;
      per_m = 0;
    end else begin
      cnt_m = (cnt_m == per_m) ? 0 : cnt_m + 1;
      if (wr_en && wr_addr == 0) per_m = int'(wr_data);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge
  task automatic wr(input int addr, input int data);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(addr);
    wr_data = CNT_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int ch, input logic lvl, output int n);
    n = 0;
    while (pin_o[ch] == lvl && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic int first_len(input int c, input int m);
    if (c == m) return PER + 1;
    return ((m - c + PER + 1) % (PER + 1)) + PER + 1;
  endfunction

  task automatic t_reset();
    check(pin_o == '0, "R1 pins after reset", int'(pin_o), 0);
  endtask

  task automatic t_setup();
    wr(0, PER);
    wr(1, 5);
    wr(2, 2);
    wr(3, 7);
    wr(4, 0);
    @(negedge clk);
    check(pin_o == '0, "R5 held pins stay low under matches", int'(pin_o), 0);
  endtask

  task automatic t_polarity();
    wr(6, 4'b0111);  // ch1: mode 01, pol 1, hold 1
    @(negedge clk);
    check(pin_o[1] == 1'b1, "R9 inactive level follows polarity", int'(pin_o[1]), 1);
    check(pin_o[0] == 1'b0 && pin_o[2] == 1'b0, "R11 others unaffected", int'(pin_o), 2);
  endtask

  task automatic t_release_stretch();
    int c, n;
    wr(5, 4'b0100);  // ch0: mode 01, pol 0, hold 0
    c = cnt_m;
    @(negedge clk);
    check(pin_o[0] == 1'b1, "R6 active at release", int'(pin_o[0]), 1);
    measure(0, 1'b1, n);
    check(n == first_len(c, 5), "R7 first active pulse stretched", n, first_len(c, 5));
    measure(0, 1'b0, n);
    check(n == PER + 1, "R2 inactive interval", n, PER + 1);
    measure(0, 1'b1, n);
    check(n == PER + 1, "R4 steady active interval", n, PER + 1);
    check(pin_o[1] == 1'b1, "R11 ch1 holds its level", int'(pin_o[1]), 1);
  endtask

  task automatic t_coincide();
    int c, n;
    // release so that the first cycle after the write has counter == 7 (ch2 compare)
    while (cnt_m != 6) @(negedge clk);
    wr(7, 4'b0100);
    c = cnt_m;
    check(c == 7, "R8 release phase setup", c, 7);
    @(negedge clk);
    check(pin_o[2] == 1'b1, "R8 active on coincident release", int'(pin_o[2]), 1);
    measure(2, 1'b1, n);
    check(n == PER + 1, "R8 no stretch on coincident release", n, PER + 1);
  endtask

  task automatic t_hold();
    int highs;
    while (pin_o[0] != 1'b1) @(negedge clk);
    wr(5, 4'b0101);  // ch0 hold again
    @(negedge clk);
    check(pin_o[0] == 1'b0, "R5 inactive after hold", int'(pin_o[0]), 0);
    highs = 0;
    for (int i = 0; i < 3 * (PER + 1); i++) begin
      @(negedge clk);
      if (pin_o[0]) highs++;
    end
    check(highs == 0, "R5 stays inactive across matches", highs, 0);
  endtask

  task automatic t_mode();
    int highs;
    wr(8, 4'b1000);  // ch3: mode 10, hold 0
    highs = 0;
    for (int i = 0; i < 3 * (PER + 1); i++) begin
      @(negedge clk);
      if (pin_o[3]) highs++;
    end
    check(highs == 0, "R10 non-toggle mode held inactive", highs, 0);
    wr(4, 3);  // R3 compare write to ch3 while gated
    @(negedge clk);
    check(pin_o[3] == 1'b0, "R10 no activation from release in other mode", int'(pin_o[3]), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_setup();
    t_polarity();
    t_release_stretch();
    t_coincide();
    t_hold();
    t_mode();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule